// File: doc/BRIEF.md
# Serial Bus Master Event Interrupt Register Block

This block gathers single-cycle event pulses from a serial bus master core and keeps each one in a sticky status bit until software clears it. Status bits are cleared by writing a 1 to them. Writing back the value just read therefore clears exactly the events that were seen.

A separate enable mask chooses which latched events may raise the interrupt. Software never writes the mask directly. One write-only offset turns enable bits on and another turns them off, so several agents can change their own sources without a read-modify-write. The mask can be read back at its own offset.

The interrupt output is a single registered level: the OR of all status bits that are also enabled. The event vector is ten bits wide:

| Bit | Event |
|-----|-------|
| 0 | completion |
| 1 | data threshold |
| 2 | NACK |
| 3 | timeout |
| 4 | slave ready |
| 5 | receive overflow |
| 6 | transmit overflow |
| 7 | receive underflow |
| 8 | reserved |
| 9 | arbitration lost |

Top module: `evt_irq_regs`

## Requirements
- R1: After reset, the status register, the mask and irq_o are all zero.
- R2: A pulse on evt_pulse bit n sets status bit n at the next clock. Status reads at offset 0x10 on bus_rdata bits [9:0], with the upper bits zero. The bit positions are listed in the table above.
- R3: A write to offset 0x10 clears each status bit whose bus_wdata bit is 1 and leaves the other bits unchanged. Writing back a value read from 0x10 clears all of the bits in that value.
- R4: If an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the event wins and the bit stays set.
- R5: A write to offset 0x24 sets each mask bit whose bus_wdata bit is 1 and leaves the others unchanged. The mask reads at offset 0x20, where a 1 means the source is enabled.
- R6: A write to offset 0x28 clears each mask bit whose bus_wdata bit is 1. Writing 0x2FF there masks every source.
- R7: irq_o is a register. It goes high one clock after (status AND mask) becomes nonzero and goes low one clock after that value becomes zero.
- R8: Status bits latch even while their source is masked. Enabling such a source later raises irq_o one clock after the mask changes.
- R9: Bit 8 is reserved. No event or write ever sets it in the status or the mask, and it always reads 0.
- R10: Reads of offset 0x24, offset 0x28 and any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset, used for both reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt_pulse | input | 10 | Event pulses from the bus master core |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Events are driven as:
- a full burst with every source masked, which shows that latching is independent of the mask;
- each single bit position in turn, which separates a correct bit map from a shifted or swapped one and confirms that the reserved bit stays 0;
- a collision between an event and a clear of the same bit, which shows whether the event or the clear has priority.

The mask is exercised with partial set and clear patterns and an all-sources disable. These tell set-and-clear behaviour apart from a direct overwrite. Sampling irq_o on the cycle before and the cycle after each change tells the one-cycle registered delay apart from a combinational output.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int EVT_BITS   = 10;
   localparam int BUS_DATA_W = 32;
   localparam int BUS_ADDR_W = 8;

   // Event bit positions; the bus master core drives evt_pulse in this order.
   localparam int EV_DONE     = 0;
   localparam int EV_THRESH   = 1;
   localparam int EV_NACK     = 2;
   localparam int EV_TMO      = 3;
   localparam int EV_SLV_RDY  = 4;
   localparam int EV_RX_OVF   = 5;
   localparam int EV_TX_OVF   = 6;
   localparam int EV_RX_UNF   = 7;
   localparam int EV_RSV      = 8;
   localparam int EV_ARB_LOST = 9;

   localparam logic [EVT_BITS-1:0] RSV_BITS = EVT_BITS'(1) << EV_RSV;

   // Register offsets
   localparam int OFS_STATUS  = 'h10;
   localparam int OFS_MASK    = 'h20;
   localparam int OFS_ENABLE  = 'h24;
   localparam int OFS_DISABLE = 'h28;
endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode #(
   parameter int ADDR_W  = evt_irq_pkg::BUS_ADDR_W,
   parameter int DATA_W  = evt_irq_pkg::BUS_DATA_W,
   parameter int EVT_W   = evt_irq_pkg::EVT_BITS,
   parameter int STAT_AD = evt_irq_pkg::OFS_STATUS,
   parameter int MASK_AD = evt_irq_pkg::OFS_MASK,
   parameter int ENA_AD  = evt_irq_pkg::OFS_ENABLE,
   parameter int DIS_AD  = evt_irq_pkg::OFS_DISABLE
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [EVT_W-1:0]  stat_i,
   input  logic [EVT_W-1:0]  mask_i,
   output logic [EVT_W-1:0]  stat_clr_o,
   output logic [EVT_W-1:0]  mask_set_o,
   output logic [EVT_W-1:0]  mask_clr_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_AD);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_AD);
   localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENA_AD);
   localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(DIS_AD);

   generate
      if (EVT_W > DATA_W) begin : g_bad_width
         $error("event vector wider than data bus");
      end
      if (STAT_AD == MASK_AD || STAT_AD == ENA_AD || STAT_AD == DIS_AD ||
          MASK_AD == ENA_AD || MASK_AD == DIS_AD || ENA_AD == DIS_AD) begin : g_bad_ofs
         $error("register offsets must be distinct");
      end
      if (STAT_AD >= (1 << ADDR_W) || MASK_AD >= (1 << ADDR_W) ||
          ENA_AD >= (1 << ADDR_W) || DIS_AD >= (1 << ADDR_W)) begin : g_bad_range
         $error("register offset outside address space");
      end
   endgenerate

   logic [EVT_W-1:0] wbits;
   assign wbits = wdata_i[EVT_W-1:0];

   assign stat_clr_o = (wr_i && addr_i == A_STAT) ? wbits : '0;
   assign mask_set_o = (wr_i && addr_i == A_ENA)  ? wbits : '0;
   assign mask_clr_o = (wr_i && addr_i == A_DIS)  ? wbits : '0;

   // The write-only offsets and unmapped offsets read as zero.
   always_comb begin
      rdata_o = '0;
      if (addr_i == A_STAT)      rdata_o = DATA_W'(stat_i);
      else if (addr_i == A_MASK) rdata_o = DATA_W'(mask_i);
   end
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
   parameter int               EVT_W    = evt_irq_pkg::EVT_BITS,
   parameter logic [EVT_W-1:0] RSV_MASK = evt_irq_pkg::RSV_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_i,
   input  logic [EVT_W-1:0] clr_i,
   output logic [EVT_W-1:0] stat_o
);
   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      if (RSV_MASK[i]) begin : g_rsv
         assign stat_o[i] = 1'b0;
      end else begin : g_live
         logic b_q;
         // An event takes priority over a clear of the same bit.
         always_ff @(posedge clk) begin
            if (!rst_n)        b_q <= 1'b0;
            else if (evt_i[i]) b_q <= 1'b1;
            else if (clr_i[i]) b_q <= 1'b0;
         end
         assign stat_o[i] = b_q;
      end
   end
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
   parameter int               EVT_W    = evt_irq_pkg::EVT_BITS,
   parameter logic [EVT_W-1:0] RSV_MASK = evt_irq_pkg::RSV_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] set_i,
   input  logic [EVT_W-1:0] clr_i,
   output logic [EVT_W-1:0] mask_o
);
   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      if (RSV_MASK[i]) begin : g_rsv
         assign mask_o[i] = 1'b0;
      end else begin : g_live
         logic m_q;
         always_ff @(posedge clk) begin
            if (!rst_n)        m_q <= 1'b0;
            else if (set_i[i]) m_q <= 1'b1;
            else if (clr_i[i]) m_q <= 1'b0;
         end
         assign mask_o[i] = m_q;
      end
   end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs #(
   parameter int               ADDR_W   = evt_irq_pkg::BUS_ADDR_W,
   parameter int               DATA_W   = evt_irq_pkg::BUS_DATA_W,
   parameter int               EVT_W    = evt_irq_pkg::EVT_BITS,
   parameter logic [EVT_W-1:0] RSV_MASK = evt_irq_pkg::RSV_BITS,
   parameter int               STAT_AD  = evt_irq_pkg::OFS_STATUS,
   parameter int               MASK_AD  = evt_irq_pkg::OFS_MASK,
   parameter int               ENA_AD   = evt_irq_pkg::OFS_ENABLE,
   parameter int               DIS_AD   = evt_irq_pkg::OFS_DISABLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [EVT_W-1:0]  evt_pulse,
   output logic              irq_o
);
   logic [EVT_W-1:0] stat_q;
   logic [EVT_W-1:0] mask_q;
   logic [EVT_W-1:0] stat_clr;
   logic [EVT_W-1:0] mask_set;
   logic [EVT_W-1:0] mask_clr;
   logic             irq_q;

   evt_irq_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W),
      .STAT_AD(STAT_AD), .MASK_AD(MASK_AD), .ENA_AD(ENA_AD), .DIS_AD(DIS_AD)
   ) dec_i (
      .addr_i(bus_addr), .wr_i(bus_wr), .wdata_i(bus_wdata),
      .stat_i(stat_q), .mask_i(mask_q),
      .stat_clr_o(stat_clr), .mask_set_o(mask_set), .mask_clr_o(mask_clr),
      .rdata_o(bus_rdata)
   );

   evt_irq_status #(.EVT_W(EVT_W), .RSV_MASK(RSV_MASK)) stat_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse), .clr_i(stat_clr), .stat_o(stat_q)
   );

   evt_irq_mask #(.EVT_W(EVT_W), .RSV_MASK(RSV_MASK)) mask_i (
      .clk(clk), .rst_n(rst_n), .set_i(mask_set), .clr_i(mask_clr), .mask_o(mask_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat_q & mask_q);
   end
   assign irq_o = irq_q;
endmodule

// File: rtl/evt_irq_regs_chk.sv
module evt_irq_regs_chk #(
   parameter int               ADDR_W   = 8,
   parameter int               DATA_W   = 32,
   parameter int               EVT_W    = 10,
   parameter logic [EVT_W-1:0] RSV_MASK = '0,
   parameter int               STAT_AD  = 'h10,
   parameter int               ENA_AD   = 'h24,
   parameter int               DIS_AD   = 'h28
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [EVT_W-1:0]  evt_pulse,
   input logic              irq_o,
   input logic [EVT_W-1:0]  stat_q,
   input logic [EVT_W-1:0]  mask_q
);
   localparam logic [EVT_W-1:0] VLD = ~RSV_MASK;

   // R2
   evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_pulse & VLD)) |=> ((stat_q & $past(evt_pulse & VLD)) == $past(evt_pulse & VLD)));

   // R3
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(STAT_AD))
      |=> ((stat_q & $past(bus_wdata[EVT_W-1:0] & ~evt_pulse)) == '0));

   // R6
   mask_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(DIS_AD) && ((bus_wdata[EVT_W-1:0] & VLD) == VLD))
      |=> (mask_q == '0));

   // R7
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_q & mask_q)) |=> irq_o);

   // R7
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(stat_q & mask_q)) |=> !irq_o);

   // R9
   rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(STAT_AD)) |-> ((bus_rdata[EVT_W-1:0] & RSV_MASK) == '0));

   // R10
   wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(ENA_AD) || bus_addr == ADDR_W'(DIS_AD)) |-> (bus_rdata == '0));
endmodule

bind evt_irq_regs evt_irq_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W), .RSV_MASK(RSV_MASK),
   .STAT_AD(STAT_AD), .ENA_AD(ENA_AD), .DIS_AD(DIS_AD)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
   .irq_o(irq_o), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/evt_irq_regs_tb_top.sv
module evt_irq_regs_tb_top;
   localparam int CLK_P = 10;
   localparam logic [7:0] A_STAT = 8'h10;
   localparam logic [7:0] A_MASK = 8'h20;
   localparam logic [7:0] A_ENA  = 8'h24;
   localparam logic [7:0] A_DIS  = 8'h28;
   localparam logic [7:0] A_NONE = 8'h30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [9:0]  evt_pulse = '0;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       req;
   } sb_item_t;
   sb_item_t sb_q[$];

   evt_irq_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq_o(irq_o)
   );

   always #(CLK_P/2) clk = ~clk;

   // Monitor: pops expected items and compares them with the outputs.
   initial begin
      forever begin
         wait (sb_q.size() != 0);
         #1;
         begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
         end
      end
   end

   // Every task starts and ends just after a falling edge.
   task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string r);
      bus_addr = a;
      sb_q.push_back('{1'b0, e, r});
      #2;
      @(negedge clk);
   endtask

   task automatic exp_irq(input bit e, input string r);
      sb_q.push_back('{1'b1, {31'b0, e}, r});
      #2;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic ev(input logic [9:0] v);
      evt_pulse = v;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   task automatic ev_wr(input logic [9:0] v, input logic [7:0] a, input logic [31:0] d);
      evt_pulse = v; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      evt_pulse = '0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      exp_rd(A_STAT, 32'h0, "R1 status");
      exp_rd(A_MASK, 32'h0, "R1 mask");
      exp_irq(1'b0, "R1 irq");

      // R2 / R9 / R8: burst while masked
      ev(10'h3FF);
      exp_rd(A_STAT, 32'h2FF, "R2 R9 burst status");
      exp_irq(1'b0, "R8 masked no irq");

      // R8 / R7: enabling a latched source
      wr(A_ENA, 32'h004);
      exp_irq(1'b0, "R7 irq lags mask");
      exp_irq(1'b1, "R8 irq after enable");
      exp_rd(A_MASK, 32'h004, "R5 mask set");

      // R3 / R7: clear single bit
      wr(A_STAT, 32'h004);
      exp_irq(1'b1, "R7 irq lags clear");
      exp_irq(1'b0, "R7 irq falls");
      exp_rd(A_STAT, 32'h2FB, "R3 one bit cleared");

      // R5 / R9: enable all including reserved and upper bits
      wr(A_ENA, 32'hFFFF_FFFF);
      exp_rd(A_MASK, 32'h2FF, "R5 R9 mask all");

      // R3: write back read value
      wr(A_STAT, 32'h2FB);
      exp_rd(A_STAT, 32'h0, "R3 write back clears");
      exp_irq(1'b0, "R7 irq low after clear");

      // R4: collision
      ev_wr(10'h002, A_STAT, 32'h002);
      exp_rd(A_STAT, 32'h002, "R4 event wins");
      wr(A_STAT, 32'h3FF);
      exp_rd(A_STAT, 32'h0, "R3 clear all");

      // R6: disable all, then partial
      wr(A_DIS, 32'h2FF);
      exp_rd(A_MASK, 32'h0, "R6 disable all");
      wr(A_ENA, 32'h0F0);
      wr(A_DIS, 32'h030);
      exp_rd(A_MASK, 32'h0C0, "R6 partial disable");
      wr(A_ENA, 32'h100);
      exp_rd(A_MASK, 32'h0C0, "R9 reserved enable ignored");

      // R8 / R7 with partial mask
      ev(10'h010);
      exp_irq(1'b0, "R8 masked source");
      exp_irq(1'b0, "R8 masked source later");
      exp_rd(A_STAT, 32'h010, "R8 latched while masked");
      ev(10'h080);
      exp_irq(1'b0, "R7 irq one cycle late");
      exp_irq(1'b1, "R7 irq rises");

      // R10: write-only and unmapped reads are zero
      exp_rd(A_ENA, 32'h0, "R10 enable offset");
      exp_rd(A_DIS, 32'h0, "R10 disable offset");
      exp_rd(A_NONE, 32'h0, "R10 unmapped");
      wr(A_STAT, 32'h090);
      exp_rd(A_STAT, 32'h0, "R3 clear pair");

      // R2 / R9: each position on its own
      for (int p = 0; p < 10; p++) begin
         logic [31:0] e;
         e = (p == 8) ? 32'h0 : (32'h1 << p);
         ev(10'(1 << p));
         exp_rd(A_STAT, e, "R2 single position");
         wr(A_STAT, 32'h1 << p);
         exp_rd(A_STAT, 32'h0, "R3 single clear");
      end

      wait (sb_q.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule